// File: doc/BRIEF.md
# Configurable Dual-Port RAM

A synchronous memory with two ports, A and B, that share one word array and one clock. Each port has its own enable, write enable, address, write data and read data, so both ports may read or write the array on the same edge. A read or a write completes on a single rising edge. The word read appears on the port's output latch right after that edge. A port can add an output register, which delays its read data by one more edge and has its own synchronous clear.

Each port has a write-mode parameter. It sets what the output latch shows after a write edge: the new word, the word it replaced, or the last value read. A further parameter turns the block into a simple dual-port memory. Port A then only writes and port B only reads, and port A's write mode is forced to old-data behaviour. Same-address collisions between the ports give a defined result.

Top module: `dual_port_ram`

## Requirements
- R1: A port with enable and write enable high stores its write data at its address on the rising edge. A later read of that address from either port returns it.
- R2: A port with enable high and write enable low shows the stored word at its address on its latch output right after the rising edge.
- R3: With a port's output register enabled, its read data appears one enabled edge later than on the latch. Until then the output keeps the previous latch value.
- R4: Write mode 0 (new data) is the default for both ports. After a write edge, the latch shows the word just written.
- R5: Write mode 1 (old data): after a write edge, the latch shows the word that was stored at that address before the write.
- R6: Write mode 2 (hold): a write edge leaves the latch holding its most recent read value.
- R7: When a port's enable is low, that port neither reads nor writes. Its latch and its output register keep their values.
- R8: When both ports write the same address on the same edge, port A's data is stored.
- R9: A port that reads an address the other port writes on the same edge returns the old word.
- R10: A high output-register clear sets that port's registered output to the reset-value parameter on the next edge. The clear works whatever the enable is. It changes neither the latch nor the array.
- R11: In simple dual-port mode, port A's latch acts as write mode 1 whatever its parameter says. Port B's write enable is ignored, so port B never writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both ports |
| enA | input | 1 | Port A enable |
| weA | input | 1 | Port A write enable |
| addrA | input | AW | Port A word address |
| dinA | input | DW | Port A write data |
| rstRegA | input | 1 | Port A synchronous output-register clear |
| doutA | output | DW | Port A read data |
| enB | input | 1 | Port B enable |
| weB | input | 1 | Port B write enable |
| addrB | input | AW | Port B word address |
| dinB | input | DW | Port B write data |
| rstRegB | input | 1 | Port B synchronous output-register clear |
| doutB | output | DW | Port B read data |

## Verification
Port A is a new-data latch port. A vector table drives it through writes, reads and disabled cycles that carry a write, so a lost write and a write made while disabled are told apart. Port B is a hold-mode registered port. Its tests put reads and writes back to back, so a missing pipeline stage, a stage that loads the wrong value, and a hold that lets write data through each change the output. Directed cases cover two writes to one address and a read while the other port writes it, where the old and new words differ. The simple dual-port instance writes an address twice with distinct words, so forced old-data behaviour shows. A port B write is then read back to prove it was dropped.

// File: rtl/dual_port_ram_pkg.sv
package dual_port_ram_pkg;

  typedef enum logic [1:0] {
    WM_WRITE_FIRST = 2'd0,
    WM_READ_FIRST  = 2'd1,
    WM_NO_CHANGE   = 2'd2
  } wrMode_e;

  typedef struct packed {
    logic wr;
    logic ldLatch;
    logic selNew;
    logic ldReg;
    logic clrReg;
  } portStrobe_t;

endpackage

// File: rtl/dual_port_ram_ctrl.sv
module dual_port_ram_ctrl
  import dual_port_ram_pkg::*;
#(
  parameter wrMode_e MODE      = WM_WRITE_FIRST,
  parameter bit      SIMPLE    = 1'b0,
  parameter bit      READ_ONLY = 1'b0
) (
  input  logic        en,
  input  logic        we,
  input  logic        rstReg,
  output portStrobe_t st
);

  localparam wrMode_e EFF_MODE = SIMPLE ? WM_READ_FIRST : MODE;
  localparam bit CAN_WRITE = !READ_ONLY;

  logic doWrite;

  always_comb begin
    doWrite    = en & we & CAN_WRITE;
    st.wr      = doWrite;
    st.ldLatch = en & ~(doWrite & (EFF_MODE == WM_NO_CHANGE));
    st.selNew  = doWrite & (EFF_MODE == WM_WRITE_FIRST);
    st.ldReg   = en;
    st.clrReg  = rstReg;
  end

endmodule

// File: rtl/dual_port_ram_core.sv
module dual_port_ram_core
  import dual_port_ram_pkg::*;
#(
  parameter int           AW        = 6,
  parameter int           DW        = 16,
  parameter bit           OUT_REG_A = 1'b0,
  parameter bit           OUT_REG_B = 1'b0,
  parameter logic [DW-1:0] RST_VAL  = '0
) (
  input  logic          clk,
  input  portStrobe_t   stA,
  input  portStrobe_t   stB,
  input  logic [AW-1:0] addrA,
  input  logic [AW-1:0] addrB,
  input  logic [DW-1:0] dinA,
  input  logic [DW-1:0] dinB,
  output logic [DW-1:0] doutA,
  output logic [DW-1:0] doutB
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  portStrobe_t [1:0]   st;
  logic [1:0][AW-1:0]  addr;
  logic [1:0][DW-1:0]  din;
  logic [1:0][DW-1:0]  doutV;

  assign st   = {stB, stA};
  assign addr = {addrB, addrA};
  assign din  = {dinB, dinA};

  // Port B is written first so that port A wins a same-address collision.
  always_ff @(posedge clk) begin
    if (st[1].wr) mem[addr[1]] <= din[1];
    if (st[0].wr) mem[addr[0]] <= din[0];
  end

  AST_COLLIDE_A_WINS: assert property (@(posedge clk) disable iff (st[0].clrReg)
    (st[0].wr && st[1].wr && addr[0] == addr[1]) |=> (mem[$past(addr[0])] == $past(din[0]))); // R8

  for (genvar p = 0; p < 2; p++) begin : g_port
    localparam bit USE_REG = (p == 0) ? OUT_REG_A : OUT_REG_B;
    localparam int OTHER   = 1 - p;

    logic [DW-1:0] rdWord;
    logic [DW-1:0] latQ;

    assign rdWord = mem[addr[p]];

    always_ff @(posedge clk) begin
      if (st[p].ldLatch) latQ <= st[p].selNew ? din[p] : rdWord;
    end

    AST_READ_OLD_ON_CROSS_WRITE: assert property (@(posedge clk) disable iff (st[p].clrReg)
      (st[p].ldLatch && !st[p].selNew && st[OTHER].wr && addr[OTHER] == addr[p])
      |=> (latQ == $past(rdWord))); // R9

    if (USE_REG) begin : g_reg
      logic [DW-1:0] regQ;
      always_ff @(posedge clk) begin
        if (st[p].clrReg)     regQ <= RST_VAL;
        else if (st[p].ldReg) regQ <= latQ;
      end
      assign doutV[p] = regQ;
    end else begin : g_latch
      logic unusedRegCtl;
      assign unusedRegCtl = ^{st[p].clrReg, st[p].ldReg};
      assign doutV[p] = latQ;
    end
  end

  assign doutA = doutV[0];
  assign doutB = doutV[1];

endmodule

// File: rtl/dual_port_ram.sv
module dual_port_ram
  import dual_port_ram_pkg::*;
#(
  parameter int            AW        = 6,
  parameter int            DW        = 16,
  parameter wrMode_e       MODE_A    = WM_WRITE_FIRST,
  parameter wrMode_e       MODE_B    = WM_WRITE_FIRST,
  parameter bit            OUT_REG_A = 1'b0,
  parameter bit            OUT_REG_B = 1'b0,
  parameter bit            SIMPLE    = 1'b0,
  parameter logic [DW-1:0] RST_VAL   = '0
) (
  input  logic          clk,
  input  logic          enA,
  input  logic          weA,
  input  logic [AW-1:0] addrA,
  input  logic [DW-1:0] dinA,
  input  logic          rstRegA,
  output logic [DW-1:0] doutA,
  input  logic          enB,
  input  logic          weB,
  input  logic [AW-1:0] addrB,
  input  logic [DW-1:0] dinB,
  input  logic          rstRegB,
  output logic [DW-1:0] doutB
);

  portStrobe_t stA;
  portStrobe_t stB;

  dual_port_ram_ctrl #(.MODE(MODE_A), .SIMPLE(SIMPLE), .READ_ONLY(1'b0)) u_ctrlA (
    .en(enA), .we(weA), .rstReg(rstRegA), .st(stA)
  );

  dual_port_ram_ctrl #(.MODE(MODE_B), .SIMPLE(SIMPLE), .READ_ONLY(SIMPLE)) u_ctrlB (
    .en(enB), .we(weB), .rstReg(rstRegB), .st(stB)
  );

  dual_port_ram_core #(
    .AW(AW), .DW(DW), .OUT_REG_A(OUT_REG_A), .OUT_REG_B(OUT_REG_B), .RST_VAL(RST_VAL)
  ) u_core (
    .clk(clk), .stA(stA), .stB(stB), .addrA(addrA), .addrB(addrB),
    .dinA(dinA), .dinB(dinB), .doutA(doutA), .doutB(doutB)
  );

  AST_IDLE_HOLD_A: assert property (@(posedge clk) disable iff (rstRegA)
    (!enA && !rstRegA) |=> $stable(doutA)); // R7

  AST_IDLE_HOLD_B: assert property (@(posedge clk) disable iff (rstRegB)
    (!enB && !rstRegB) |=> $stable(doutB)); // R7

  if (!SIMPLE && MODE_A == WM_WRITE_FIRST && !OUT_REG_A) begin : g_echoA
    AST_WF_ECHO_A: assert property (@(posedge clk) disable iff (rstRegA)
      (enA && weA) |=> (doutA == $past(dinA))); // R4
  end

endmodule

// File: tb/tb_dual_port_ram.sv
module tb_dual_port_ram;
  import dual_port_ram_pkg::*;

  localparam int AW = 6;
  localparam int DW = 16;
  localparam logic [DW-1:0] RV = 16'h5A5A;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          enA, weA, rstRegA, enB, weB, rstRegB;
  logic [AW-1:0] addrA, addrB;
  logic [DW-1:0] dinA, dinB, doutA, doutB;

  logic          sEnA, sWeA, sEnB, sWeB;
  logic [AW-1:0] sAddrA, sAddrB;
  logic [DW-1:0] sDinA, sDinB, sDoutA, sDoutB;

  dual_port_ram #(.AW(AW), .DW(DW), .MODE_A(WM_WRITE_FIRST), .MODE_B(WM_NO_CHANGE),
    .OUT_REG_A(1'b0), .OUT_REG_B(1'b1), .SIMPLE(1'b0), .RST_VAL(RV)) dut (
    .clk(clk), .enA(enA), .weA(weA), .addrA(addrA), .dinA(dinA), .rstRegA(rstRegA), .doutA(doutA),
    .enB(enB), .weB(weB), .addrB(addrB), .dinB(dinB), .rstRegB(rstRegB), .doutB(doutB));

  dual_port_ram #(.AW(AW), .DW(DW), .MODE_A(WM_WRITE_FIRST), .MODE_B(WM_WRITE_FIRST),
    .OUT_REG_A(1'b0), .OUT_REG_B(1'b0), .SIMPLE(1'b1), .RST_VAL(RV)) dutSdp (
    .clk(clk), .enA(sEnA), .weA(sWeA), .addrA(sAddrA), .dinA(sDinA), .rstRegA(1'b0), .doutA(sDoutA),
    .enB(sEnB), .weB(sWeB), .addrB(sAddrB), .dinB(sDinB), .rstRegB(1'b0), .doutB(sDoutB));

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // Fields: en[39] we[38] addr[37:32] din[31:16] expected doutA[15:0]
  localparam int NV = 6;
  localparam logic [39:0] VEC [NV] = '{
    {1'b1, 1'b1, 6'd3, 16'h1111, 16'h1111},  // R4 write shows new word
    {1'b1, 1'b1, 6'd4, 16'h2222, 16'h2222},  // R4
    {1'b1, 1'b0, 6'd3, 16'h0000, 16'h1111},  // R1 R2 read back
    {1'b0, 1'b1, 6'd3, 16'h9999, 16'h1111},  // R7 disabled holds
    {1'b1, 1'b0, 6'd3, 16'h0000, 16'h1111},  // R7 disabled write not stored
    {1'b1, 1'b0, 6'd4, 16'h0000, 16'h2222}   // R2
  };

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    enA = 0; weA = 0; addrA = '0; dinA = '0; rstRegA = 1;
    enB = 0; weB = 0; addrB = '0; dinB = '0; rstRegB = 1;
    sEnA = 0; sWeA = 0; sAddrA = '0; sDinA = '0;
    sEnB = 0; sWeB = 0; sAddrB = '0; sDinB = '0;
    @(negedge clk);
    tick();
    check("R10 reset value", doutB, RV);
    rstRegA = 0; rstRegB = 0;

    for (int i = 0; i < NV; i++) begin
      {enA, weA, addrA, dinA} = VEC[i][39:16];
      tick();
      check($sformatf("R1/R2/R4/R7 vector %0d", i), doutA, VEC[i][15:0]);
    end
    enA = 0; weA = 0;

    // R3: registered port B, prime with 2222 then read 1111
    enB = 1; weB = 0; addrB = 6'd4;
    tick(); tick();
    check("R3 primed", doutB, 16'h2222);
    addrB = 6'd3;
    tick();
    check("R3 one edge still old", doutB, 16'h2222);
    tick();
    check("R3 second edge new", doutB, 16'h1111);

    // R6: hold-mode write keeps last read
    weB = 1; addrB = 6'd5; dinB = 16'h7777;
    tick();
    check("R6 hold after write", doutB, 16'h1111);
    tick();
    check("R6 hold second write", doutB, 16'h1111);
    enB = 0; weB = 0;
    enA = 1; weA = 0; addrA = 6'd5;
    tick();
    check("R1 port B write seen by A", doutA, 16'h7777);
    enA = 0;

    // R10: clear register, latch untouched
    rstRegB = 1;
    tick();
    check("R10 clear", doutB, RV);
    rstRegB = 0;
    enB = 1; weB = 1; addrB = 6'd6; dinB = 16'h1234;
    tick();
    check("R10 latch kept", doutB, 16'h1111);
    enB = 0; weB = 0;

    // R8: same-address double write
    enA = 1; weA = 1; addrA = 6'd10; dinA = 16'hAAAA;
    enB = 1; weB = 1; addrB = 6'd10; dinB = 16'hBBBB;
    tick();
    check("R4 collision echo", doutA, 16'hAAAA);
    enB = 0; weB = 0; weA = 0;
    tick();
    check("R8 port A stored", doutA, 16'hAAAA);

    // R9: B reads while A writes the same address
    weA = 1; addrA = 6'd11; dinA = 16'h1357;
    tick();
    dinA = 16'h2468;
    enB = 1; weB = 0; addrB = 6'd11;
    tick();
    enA = 0; weA = 0;
    weB = 1; addrB = 6'd20; dinB = 16'h0000;
    tick();
    check("R9 old word read", doutB, 16'h1357);
    enB = 0; weB = 0;
    enA = 1; addrA = 6'd11;
    tick();
    check("R1 new word stored", doutA, 16'h2468);
    enA = 0;

    // R7 on port B: disabled write
    enB = 0; weB = 1; addrB = 6'd11; dinB = 16'hFFFF;
    tick();
    check("R7 port B output held", doutB, 16'h1357);
    weB = 0;
    enA = 1; addrA = 6'd11;
    tick();
    check("R7 disabled write dropped", doutA, 16'h2468);
    enA = 0;

    // R5 R11: simple dual-port instance
    sEnA = 1; sWeA = 1; sAddrA = 6'd2; sDinA = 16'h0001;
    tick();
    sDinA = 16'h0002;
    tick();
    check("R5 R11 forced old data", sDoutA, 16'h0001);
    sEnA = 0; sWeA = 0;
    sEnB = 1; sWeB = 1; sAddrB = 6'd2; sDinB = 16'hFFFF;
    tick();
    check("R11 read-only port reads", sDoutB, 16'h0002);
    sWeB = 0;
    tick();
    check("R11 port B write ignored", sDoutB, 16'h0002);
    sEnB = 0;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule